// File: doc/BRIEF.md
# Timer Run Control and External Interrupt Flag Register

This block is a single 8-bit control and status register on a simple special-function-register bus. Software reaches it in two ways. A byte write addressed to the register replaces all eight bits. A single-bit write, decoded from a bit address, changes exactly one bit. A read with the register's address returns the whole byte on a combinational read port. The register holds the run-enable bits for two timers and drives them straight out to those timers. It also latches the overflow events that the timers report.

The lower half of the register serves two external interrupt pins. Each pin passes through a two-flop synchronizer and is then adjusted by a per-pin polarity input. A per-pin mode bit selects edge or level sensing. In edge mode, an inactive-to-active transition sets the pin's flag, and the flag holds until software clears it or the CPU acknowledges the vector. In level mode the flag follows the qualified pin level every clock, so neither a software clear nor an acknowledge has a lasting effect.

Whenever a hardware set event meets a clear in the same cycle, the set wins, so no event is lost.

Top module: `tmr_xint_ctl`

## Requirements
- R1: After reset the register reads 0x00: both run outputs are low, all four flags are low and both pins are in level mode. Bit positions are: 7 timer-1 overflow flag, 6 timer-1 run, 5 timer-0 overflow flag, 4 timer-0 run, 3 pin-1 flag, 2 pin-1 mode, 1 pin-0 flag, 0 pin-0 mode.
- R2: A byte write (`busWrEn`=1, `busAddr`=0x88) replaces all eight bits at the next clock. `rdData` shows the register whenever `busAddr`=0x88 and shows 0x00 for any other address.
- R3: A single-bit write (`bitWrEn`=1) whose `bitAddr[7:3]` equals 0x11 writes `bitVal` into bit `bitAddr[2:0]` and leaves the other seven bits unchanged. A single-bit write to any other bit address changes nothing.
- R4: `runEn[1]` equals bit 6 and `runEn[0]` equals bit 4, and both change only through software writes.
- R5: A one-cycle pulse on `ovfEvt[k]` sets the timer-k overflow flag at the next clock. This holds even when a software write of 0 or an acknowledge hits that bit in the same cycle.
- R6: A pulse on `ackTmr[k]` clears the timer-k overflow flag at the next clock, provided no overflow event and no software write reaches that bit in the same cycle.
- R7: `extPin[k]` is active when it equals `extPolHigh[k]`. A change on the pin reaches the flag after three rising clock edges (two synchronizer stages plus the flag register).
- R8: In edge mode (mode bit 1), an inactive-to-active transition of the qualified pin sets the flag. The flag stays set after the pin returns inactive, until `ackExt[k]` or a software write clears it. An edge arriving in the same cycle as an acknowledge leaves the flag set.
- R9: In level mode (mode bit 0), the flag equals the qualified pin level one clock after the synchronizer output. A software clear or an `ackExt[k]` pulse while the pin stays active does not drop it.
- R10: If a software write and an acknowledge reach the same flag in the same cycle with no hardware set event, the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register address for byte writes and reads |
| busWrEn | input | 1 | Byte write strobe |
| busWrData | input | 8 | Byte write data |
| bitWrEn | input | 1 | Single-bit write strobe |
| bitAddr | input | 8 | Bit address for single-bit writes |
| bitVal | input | 1 | Value written by a single-bit write |
| rdData | output | 8 | Read data |
| ovfEvt | input | 2 | Overflow pulses from timer 1 and timer 0 |
| ackTmr | input | 2 | Vector acknowledge for timer 1 and timer 0 interrupts |
| ackExt | input | 2 | Vector acknowledge for pin 1 and pin 0 interrupts |
| extPin | input | 2 | Asynchronous external interrupt pins |
| extPolHigh | input | 2 | Per-pin polarity, 1 = active high, 0 = active low |
| runEn | output | 2 | Run enables to timer 1 and timer 0 |
| tmrFlag | output | 2 | Timer overflow flags to the interrupt controller |
| extFlag | output | 2 | External pin flags to the interrupt controller |

## Verification
The functions that collide are a hardware set (a timer overflow or a detected pin edge) and a clear (a software write or a vector acknowledge) on the same flag bit. The bench provokes this by pulsing an overflow in the same cycle as a single-bit clear or an acknowledge. It also lines up an acknowledge with the exact clock on which a synchronized pin edge reaches the flag, counting the three register stages from the pin. The bench judges these cases by reading the flag afterwards and expecting it set. A separate case pairs a write with an acknowledge and expects the written value.

// File: rtl/tcx_pkg.sv
package tcx_pkg;
  localparam int REG_W     = 8;
  localparam int N_CH      = 2;
  localparam int CH_STRIDE = 2;
  localparam int OVF_BASE  = 5;  // timer flags at 5 and 7
  localparam int RUN_BASE  = 4;  // run bits at 4 and 6
  localparam int XF_BASE   = 1;  // pin flags at 1 and 3
  localparam int XM_BASE   = 0;  // pin modes at 0 and 2

  typedef struct packed {
    logic [REG_W-1:0] wrMask;
    logic [REG_W-1:0] wrVal;
  } sw_strobe_t;
endpackage

// File: rtl/tcx_ctrl.sv
module tcx_ctrl
  import tcx_pkg::*;
#(
  parameter logic [7:0] REG_ADDR = 8'h88
) (
  input  logic [7:0]       busAddr,
  input  logic             busWrEn,
  input  logic [REG_W-1:0] busWrData,
  input  logic             bitWrEn,
  input  logic [7:0]       bitAddr,
  input  logic             bitVal,
  output sw_strobe_t       strb
);
  logic byteHit;
  logic bitHit;

  assign byteHit = busWrEn && (busAddr == REG_ADDR);
  assign bitHit  = bitWrEn && (bitAddr[7:3] == REG_ADDR[7:3]);

  always_comb begin
    strb.wrMask = '0;
    strb.wrVal  = busWrData;
    if (byteHit) begin
      strb.wrMask = '1;
    end else if (bitHit) begin
      strb.wrMask[bitAddr[2:0]] = 1'b1;
      strb.wrVal = {REG_W{bitVal}};
    end
  end
endmodule

// File: rtl/tcx_pin_sync.sv
module tcx_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  input  logic polHigh,
  output logic active,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prevActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain      <= '0;
      prevActive <= 1'b0;
    end else begin
      chain      <= {chain[STAGES-2:0], pinIn};
      prevActive <= active;
    end
  end

  assign active = polHigh ? chain[STAGES-1] : ~chain[STAGES-1];
  assign rise   = active & ~prevActive;
endmodule

// File: rtl/tcx_datapath.sv
module tcx_datapath
  import tcx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  sw_strobe_t       strb,
  input  logic [N_CH-1:0]  ovfEvt,
  input  logic [N_CH-1:0]  ackTmr,
  input  logic [N_CH-1:0]  ackExt,
  input  logic [N_CH-1:0]  extActive,
  input  logic [N_CH-1:0]  extRise,
  output logic [REG_W-1:0] regQ
);
  logic [REG_W-1:0] regNxt;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    localparam int OB = OVF_BASE + CH_STRIDE * k;
    localparam int RB = RUN_BASE + CH_STRIDE * k;
    localparam int FB = XF_BASE + CH_STRIDE * k;
    localparam int MB = XM_BASE + CH_STRIDE * k;

    logic ovfKept;
    logic extKept;

    // software write beats acknowledge; hardware set beats both
    assign ovfKept = strb.wrMask[OB] ? strb.wrVal[OB] : (ackTmr[k] ? 1'b0 : regQ[OB]);
    assign extKept = strb.wrMask[FB] ? strb.wrVal[FB] : (ackExt[k] ? 1'b0 : regQ[FB]);

    assign regNxt[OB] = ovfEvt[k] | ovfKept;
    assign regNxt[RB] = strb.wrMask[RB] ? strb.wrVal[RB] : regQ[RB];
    assign regNxt[MB] = strb.wrMask[MB] ? strb.wrVal[MB] : regQ[MB];
    assign regNxt[FB] = regQ[MB] ? (extRise[k] | extKept) : extActive[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else       regQ <= regNxt;
  end
endmodule

// File: rtl/tmr_xint_ctl.sv
module tmr_xint_ctl
  import tcx_pkg::*;
#(
  parameter logic [7:0] REG_ADDR    = 8'h88,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busAddr,
  input  logic       busWrEn,
  input  logic [7:0] busWrData,
  input  logic       bitWrEn,
  input  logic [7:0] bitAddr,
  input  logic       bitVal,
  output logic [7:0] rdData,
  input  logic [1:0] ovfEvt,
  input  logic [1:0] ackTmr,
  input  logic [1:0] ackExt,
  input  logic [1:0] extPin,
  input  logic [1:0] extPolHigh,
  output logic [1:0] runEn,
  output logic [1:0] tmrFlag,
  output logic [1:0] extFlag
);
  sw_strobe_t       strb;
  logic [N_CH-1:0]  extActive;
  logic [N_CH-1:0]  extRise;
  logic [REG_W-1:0] regQ;

  tcx_ctrl #(.REG_ADDR(REG_ADDR)) u_ctrl (
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .bitWrEn  (bitWrEn),
    .bitAddr  (bitAddr),
    .bitVal   (bitVal),
    .strb     (strb)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_pin
    tcx_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rstN   (rstN),
      .pinIn  (extPin[k]),
      .polHigh(extPolHigh[k]),
      .active (extActive[k]),
      .rise   (extRise[k])
    );
    assign runEn[k]   = regQ[RUN_BASE + CH_STRIDE * k];
    assign tmrFlag[k] = regQ[OVF_BASE + CH_STRIDE * k];
    assign extFlag[k] = regQ[XF_BASE + CH_STRIDE * k];
  end

  tcx_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ovfEvt   (ovfEvt),
    .ackTmr   (ackTmr),
    .ackExt   (ackExt),
    .extActive(extActive),
    .extRise  (extRise),
    .regQ     (regQ)
  );

  assign rdData = (busAddr == REG_ADDR) ? regQ : '0;
endmodule

// File: rtl/tmr_xint_ctl_chk.sv
module tmr_xint_ctl_chk #(
  parameter logic [7:0] REG_ADDR = 8'h88
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] busAddr,
  input logic       busWrEn,
  input logic [7:0] busWrData,
  input logic       bitWrEn,
  input logic [7:0] bitAddr,
  input logic [1:0] ovfEvt,
  input logic [1:0] ackTmr,
  input logic [1:0] runEn,
  input logic [1:0] tmrFlag
);
  logic byteHit;
  logic anyHit;
  assign byteHit = busWrEn && (busAddr == REG_ADDR);
  assign anyHit  = byteHit || (bitWrEn && (bitAddr[7:3] == REG_ADDR[7:3]));

  assert_ovf0_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt[0] |=> tmrFlag[0]);
  assert_ovf1_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt[1] |=> tmrFlag[1]);
  assert_ack0_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackTmr[0] && !ovfEvt[0] && !anyHit) |=> !tmrFlag[0]);
  assert_ack1_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackTmr[1] && !ovfEvt[1] && !anyHit) |=> !tmrFlag[1]);
  assert_run_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    !anyHit |=> $stable(runEn));
  assert_byte_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    byteHit |=> (runEn == {$past(busWrData[6]), $past(busWrData[4])}));
endmodule

bind tmr_xint_ctl tmr_xint_ctl_chk #(.REG_ADDR(REG_ADDR)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .bitWrEn  (bitWrEn),
  .bitAddr  (bitAddr),
  .ovfEvt   (ovfEvt),
  .ackTmr   (ackTmr),
  .runEn    (runEn),
  .tmrFlag  (tmrFlag)
);

// File: tb/test_tmr_xint_ctl.sv
`timescale 1ns/1ps
module test_tmr_xint_ctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h88;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic       bitWrEn = 1'b0;
  logic [7:0] bitAddr = 8'h00;
  logic       bitVal = 1'b0;
  logic [7:0] rdData;
  logic [1:0] ovfEvt = 2'b00;
  logic [1:0] ackTmr = 2'b00;
  logic [1:0] ackExt = 2'b00;
  logic [1:0] extPin = 2'b00;
  logic [1:0] extPolHigh = 2'b11;
  logic [1:0] runEn;
  logic [1:0] tmrFlag;
  logic [1:0] extFlag;

  int nChk = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  tmr_xint_ctl i_tmr_xint_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .bitWrEn(bitWrEn), .bitAddr(bitAddr), .bitVal(bitVal),
    .rdData(rdData), .ovfEvt(ovfEvt), .ackTmr(ackTmr), .ackExt(ackExt),
    .extPin(extPin), .extPolHigh(extPolHigh), .runEn(runEn),
    .tmrFlag(tmrFlag), .extFlag(extFlag)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrByte(input logic [7:0] d);
    busAddr = 8'h88; busWrData = d; busWrEn = 1'b1;
    cyc(1);
    busWrEn = 1'b0;
  endtask

  task automatic wrBit(input logic [7:0] a, input logic v);
    bitAddr = a; bitVal = v; bitWrEn = 1'b1;
    cyc(1);
    bitWrEn = 1'b0;
  endtask

  function automatic logic [7:0] rdReg();
    return rdData;
  endfunction

  task automatic t_reset();
    busAddr = 8'h88; #1;
    chk("R1 reset value", rdReg(), 8'h00);
    chk("R1 run outputs", {6'd0, runEn}, 8'h00);
    chk("R1 flag outputs", {4'd0, tmrFlag, extFlag}, 8'h00);
  endtask

  task automatic t_byte();
    wrByte(8'h50); #1;
    chk("R2 byte write readback", rdReg(), 8'h50);
    chk("R4 run outputs follow bits 6,4", {6'd0, runEn}, 8'h03);
    wrByte(8'hA5); #1;
    chk("R2 second byte write", rdReg(), 8'hA5);
    busAddr = 8'h89; #1;
    chk("R2 other address reads zero", rdReg(), 8'h00);
    busAddr = 8'h88;
    wrByte(8'h00); #1;
    chk("R2 clear by byte write", rdReg(), 8'h00);
  endtask

  task automatic t_bit();
    wrBit(8'h8E, 1'b1); #1;
    chk("R3 set bit 6", rdReg(), 8'h40);
    chk("R4 runEn after bit set", {6'd0, runEn}, 8'h02);
    wrBit(8'h8C, 1'b1); #1;
    chk("R3 set bit 4", rdReg(), 8'h50);
    wrBit(8'h8E, 1'b0); #1;
    chk("R3 clear bit 6 only", rdReg(), 8'h10);
    wrBit(8'h96, 1'b1); #1;
    chk("R3 foreign bit address ignored", rdReg(), 8'h10);
    wrByte(8'h00);
  endtask

  task automatic t_ovf();
    ovfEvt = 2'b01; cyc(1); ovfEvt = 2'b00; #1;
    chk("R5 timer0 overflow sets bit 5", rdReg(), 8'h20);
    ackTmr = 2'b01; cyc(1); ackTmr = 2'b00; #1;
    chk("R6 ack clears timer0 flag", rdReg(), 8'h00);
    ovfEvt = 2'b10; cyc(1); ovfEvt = 2'b00; #1;
    chk("R5 timer1 overflow sets bit 7", rdReg(), 8'h80);
    wrBit(8'h8F, 1'b0); #1;
    chk("R3 bit clear of timer1 flag", rdReg(), 8'h00);
    ovfEvt = 2'b10; bitAddr = 8'h8F; bitVal = 1'b0; bitWrEn = 1'b1;
    cyc(1);
    ovfEvt = 2'b00; bitWrEn = 1'b0; #1;
    chk("R5 set beats same-cycle bit clear", rdReg(), 8'h80);
    ovfEvt = 2'b01; ackTmr = 2'b01; cyc(1); ovfEvt = 2'b00; ackTmr = 2'b00; #1;
    chk("R5 set beats same-cycle ack", rdReg(), 8'hA0);
    ackTmr = 2'b11; cyc(1); ackTmr = 2'b00; #1;
    chk("R6 ack clears both timer flags", rdReg(), 8'h00);
  endtask

  task automatic t_write_vs_ack();
    busAddr = 8'h88; busWrData = 8'h20; busWrEn = 1'b1; ackTmr = 2'b01;
    cyc(1);
    busWrEn = 1'b0; ackTmr = 2'b00; #1;
    chk("R10 write value kept over ack", rdReg(), 8'h20);
    wrByte(8'h00);
  endtask

  task automatic t_edge();
    wrByte(8'h05);
    extPin[0] = 1'b1;
    cyc(2); #1;
    chk("R7 no flag after two edges", {7'd0, extFlag[0]}, 8'h00);
    cyc(1); #1;
    chk("R7 R8 edge flag after three edges", rdReg(), 8'h07);
    extPin[0] = 1'b0;
    cyc(4); #1;
    chk("R8 flag held after pin inactive", {7'd0, extFlag[0]}, 8'h01);
    ackExt = 2'b01; cyc(1); ackExt = 2'b00; #1;
    chk("R8 ack clears edge flag", rdReg(), 8'h05);
    // edge reaches flag on the third edge; ack lands on that same edge
    extPin[0] = 1'b1;
    cyc(2);
    ackExt = 2'b01; cyc(1); ackExt = 2'b00; #1;
    chk("R8 edge beats same-cycle ack", {7'd0, extFlag[0]}, 8'h01);
    extPin[0] = 1'b0;
    ackExt = 2'b01; cyc(1); ackExt = 2'b00;
    // active-low pin 1: park inactive, discard any transient flag
    extPin[1] = 1'b1; extPolHigh[1] = 1'b0;
    cyc(4);
    ackExt = 2'b10; cyc(1); ackExt = 2'b00; #1;
    chk("R7 active-low pin parked inactive", rdReg(), 8'h05);
    extPin[1] = 1'b0;
    cyc(3); #1;
    chk("R7 active-low falling edge sets pin1 flag", {6'd0, extFlag}, 8'h02);
    ackExt = 2'b10; cyc(1); ackExt = 2'b00;
    extPin[1] = 1'b1; cyc(1);
    extPolHigh[1] = 1'b1; extPin[1] = 1'b0;
    cyc(4);
    ackExt = 2'b11; cyc(1); ackExt = 2'b00;
    wrByte(8'h00); cyc(1); #1;
    chk("R8 state cleaned up", rdReg(), 8'h00);
  endtask

  task automatic t_level();
    extPin[0] = 1'b1;
    cyc(3); #1;
    chk("R9 level flag follows pin", rdReg(), 8'h02);
    wrBit(8'h89, 1'b0); #1;
    chk("R9 software clear has no effect", {7'd0, extFlag[0]}, 8'h01);
    ackExt = 2'b01; cyc(1); ackExt = 2'b00; #1;
    chk("R9 ack has no effect in level mode", {7'd0, extFlag[0]}, 8'h01);
    extPin[0] = 1'b0;
    cyc(2); #1;
    chk("R9 flag still set before sync delay", {7'd0, extFlag[0]}, 8'h01);
    cyc(1); #1;
    chk("R9 flag drops with pin", rdReg(), 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    cyc(4);
    rstN = 1'b1;
    cyc(1);
    t_reset();
    t_byte();
    t_bit();
    t_ovf();
    t_write_vs_ack();
    t_edge();
    t_level();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule